// File: doc/BRIEF.md
# Line Error Low-Pulse Generator

This block signals a receive error on a shared single-wire control line that idles high. When the receiver logic flags an error, the block pulls the line low for 3600 microsecond ticks (3.6 ms) through an active-low open-drain enable, so every other node on the line learns that the frame failed. Bit decoding and error detection happen elsewhere. This block only takes the one-cycle error strobe and the raw line level.

A deferred mode handles the case where the line is already low when the error is seen. The block then waits for the next rising edge of the line and starts its pulse from that edge. If no rising edge comes within 3600 ticks, the pulse is dropped, because another node is assumed to have already held the line low for the error. Either outcome raises a one-cycle completion flag.

The block also keeps a sticky flag that records any low level seen on the synchronized line. A clear input resets the flag and holds it at zero.

Top module: `cec_error_pulser`

## Requirements
- R1: While `pulse_en` is 0, an error strobe starts neither a pulse nor a wait. `drive_low_n` stays 1, `done` stays 0, and `wait_mode` has no effect.
- R2: With `pulse_en` 1 and `wait_mode` 0, `drive_low_n` goes to 0 on the cycle after the strobe edge and stays 0 for exactly `PULSE_TICKS` ticks.
- R3: With `wait_mode` 1 and the synchronized line high at the strobe, the pulse starts at once, just as in R2.
- R4: With `wait_mode` 1 and the synchronized line low at the strobe, `drive_low_n` stays 1 until a rising edge is detected on the synchronized line. The pulse of `PULSE_TICKS` ticks then starts on the next cycle.
- R5: If no rising edge is detected within `WAIT_TICKS` ticks after the strobe, no pulse is driven. `done` rises on the cycle after the `WAIT_TICKS`-th tick.
- R6: `wait_mode` is sampled only when the strobe arrives. Changing it during a wait or a pulse has no effect.
- R7: An error strobe that arrives while a wait or a pulse is active is ignored. The pulse length and the completion time do not change.
- R8: `done` is high for exactly one cycle, on the cycle where `drive_low_n` returns to 1 after a pulse, or when a wait is dropped.
- R9: `rx_edge_flag` becomes 1 one cycle after the synchronized line is seen low while `edge_clr` is 0. It is 0 on the cycle after `edge_clr` is 1, and `edge_clr` takes priority.
- R10: The line passes through a 2-flop synchronizer that resets to high. Pulse and wait counters advance only on cycles where `tick_us` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_us | input | 1 | One-cycle 1 µs timing enable |
| line_in | input | 1 | Raw level of the control line |
| err_strobe | input | 1 | One-cycle receive-error indication |
| pulse_en | input | 1 | Enables the error pulse function |
| wait_mode | input | 1 | 1: defer the pulse to the next rising edge when the line is low |
| edge_clr | input | 1 | Clears and holds the receive-edge flag at 0 |
| drive_low_n | output | 1 | Active-low open-drain pull-down enable |
| done | output | 1 | One-cycle flag when a pulse ends or a wait is dropped |
| rx_edge_flag | output | 1 | Sticky flag set by a low line level |

## Verification
A wrong controller state shows up at `drive_low_n` within one cycle of the strobe, or three cycles after the line is raised in a wait. The wrong state is either a pulse that should not exist or a missing one. A counter that is off by one moves the rise of `done` and the pulse length by one cycle, so the bench measures the exact sample index of the first low and of `done` for each rising-edge delay across the whole wait window. The window includes the point where the edge arrives just too late. Faults in the edge flag appear at `rx_edge_flag` by the third cycle after the line changes.

// File: rtl/cec_errp_pkg.sv
package cec_errp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2
    } errp_state_e;
endpackage

// File: rtl/cec_errp_sync.sv
module cec_errp_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_rise
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = line_raw;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{meta: 1'b1, stable: 1'b1, prev: 1'b1};
        else        sync_q <= sync_d;
    end

    assign line_s    = sync_q.stable;
    assign line_rise = sync_q.stable & ~sync_q.prev;

    // R10: a detected rise means the stable value was low one cycle earlier
    assert_rise_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_rise |-> $past(!line_s));
endmodule

// File: rtl/cec_errp_edgeflag.sv
module cec_errp_edgeflag (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic edge_clr,
    output logic flag
);
    typedef struct packed {
        logic seen_low;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (edge_clr)     flag_d.seen_low = 1'b0;
        else if (!line_s) flag_d.seen_low = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q.seen_low;

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        edge_clr |=> !flag);
    assert_low_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_s && !edge_clr) |=> flag);
endmodule

// File: rtl/cec_errp_ctrl.sv
module cec_errp_ctrl #(
    parameter int PULSE_TICKS = 3600,
    parameter int WAIT_TICKS  = 3600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic err_strobe,
    input  logic pulse_en,
    input  logic wait_mode,
    input  logic line_s,
    input  logic line_rise,
    output logic drive_low_n,
    output logic done
);
    import cec_errp_pkg::*;

    localparam int MAX_TICKS = (PULSE_TICKS > WAIT_TICKS) ? PULSE_TICKS : WAIT_TICKS;
    localparam int CNT_W     = (MAX_TICKS > 2) ? $clog2(MAX_TICKS) : 1;
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_TICKS - 1);

    typedef struct packed {
        errp_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (err_strobe && pulse_en) begin
                    ctrl_d.cnt   = '0;
                    ctrl_d.state = (wait_mode && !line_s) ? ST_WAIT : ST_PULSE;
                end
            end
            ST_WAIT: begin
                if (line_rise) begin
                    ctrl_d.state = ST_PULSE;
                    ctrl_d.cnt   = '0;
                end else if (tick_us) begin
                    if (ctrl_q.cnt == WAIT_LAST) begin
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.cnt   = '0;
                        ctrl_d.done  = 1'b1;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            ST_PULSE: begin
                if (tick_us) begin
                    if (ctrl_q.cnt == PULSE_LAST) begin
                        ctrl_d.state = ST_IDLE;
                        ctrl_d.cnt   = '0;
                        ctrl_d.done  = 1'b1;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            default: ctrl_d = '{state: ST_IDLE, cnt: '0, done: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{state: ST_IDLE, cnt: '0, done: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign drive_low_n = (ctrl_q.state != ST_PULSE);
    assign done        = ctrl_q.done;

    assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE && err_strobe && !pulse_en) |=> drive_low_n && !done);
    assert_direct_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE && err_strobe && pulse_en && !wait_mode) |=> !drive_low_n);
    assert_wait_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_WAIT && !line_rise) |=> drive_low_n);
    assert_pulse_leaves_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_low_n && tick_us && ctrl_q.cnt == PULSE_LAST) |=> drive_low_n && done);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_counter_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_us && ctrl_q.state != ST_IDLE && !line_rise |=> $stable(ctrl_q.cnt));
    assert_busy_strobe_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_PULSE && !tick_us) |=> !drive_low_n);
endmodule

// File: rtl/cec_error_pulser.sv
module cec_error_pulser #(
    parameter int PULSE_TICKS = 3600,
    parameter int WAIT_TICKS  = 3600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic line_in,
    input  logic err_strobe,
    input  logic pulse_en,
    input  logic wait_mode,
    input  logic edge_clr,
    output logic drive_low_n,
    output logic done,
    output logic rx_edge_flag
);
    logic line_s;
    logic line_rise;

    cec_errp_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .line_s    (line_s),
        .line_rise (line_rise)
    );

    cec_errp_ctrl #(
        .PULSE_TICKS (PULSE_TICKS),
        .WAIT_TICKS  (WAIT_TICKS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_us     (tick_us),
        .err_strobe  (err_strobe),
        .pulse_en    (pulse_en),
        .wait_mode   (wait_mode),
        .line_s      (line_s),
        .line_rise   (line_rise),
        .drive_low_n (drive_low_n),
        .done        (done)
    );

    cec_errp_edgeflag u_edgeflag (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .edge_clr (edge_clr),
        .flag     (rx_edge_flag)
    );
endmodule

// File: tb/cec_error_pulser_bench.sv
module cec_error_pulser_bench;
    localparam int P = 6;
    localparam int W = 8;
    localparam int LIM = P + W + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b1;
    logic line_in = 1'b1;
    logic err_strobe = 1'b0;
    logic pulse_en = 1'b0;
    logic wait_mode = 1'b0;
    logic edge_clr = 1'b0;
    logic drive_low_n, done, rx_edge_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cec_error_pulser #(.PULSE_TICKS(P), .WAIT_TICKS(W)) u_cec_error_pulser (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .line_in(line_in),
        .err_strobe(err_strobe), .pulse_en(pulse_en), .wait_mode(wait_mode),
        .edge_clr(edge_clr), .drive_low_n(drive_low_n), .done(done),
        .rx_edge_flag(rx_edge_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe at a negedge, runs LIM samples. Index 1 is the negedge right after the strobe edge.
    task automatic run_case(input int raise_at, input int restrobe_at, input int flip_at,
                            output int first_low, output int first_done, output int lows,
                            output int dones);
        first_low = 0; first_done = 0; lows = 0; dones = 0;
        @(negedge clk) err_strobe = 1'b1;
        @(negedge clk) err_strobe = 1'b0;
        for (int i = 1; i <= LIM; i++) begin
            if (!drive_low_n) begin
                lows++;
                if (first_low == 0) first_low = i;
            end
            if (done) begin
                dones++;
                if (first_done == 0) first_done = i;
            end
            err_strobe = (i == restrobe_at);
            if (i == raise_at) line_in = 1'b1;
            if (i == flip_at) wait_mode = ~wait_mode;
            @(negedge clk);
        end
        err_strobe = 1'b0;
    endtask

    task automatic set_line_low();
        @(negedge clk) line_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int fl, fd, nl, nd, exp_low, exp_done;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_low_n == 1'b1, "R10 reset drive", drive_low_n, 1);
        check(done == 1'b0, "R8 reset done", done, 0);
        check(rx_edge_flag == 1'b0, "R10 reset sync high keeps flag", rx_edge_flag, 0);

        // R1: disabled, with either wait setting and either line level
        for (int wm = 0; wm < 2; wm++) begin
            for (int lv = 0; lv < 2; lv++) begin
                pulse_en = 1'b0; wait_mode = wm[0];
                if (lv == 0) set_line_low();
                run_case(3, 0, 0, fl, fd, nl, nd);
                check(nl == 0, "R1 disabled no pulse", nl, 0);
                check(nd == 0, "R1 disabled no done", nd, 0);
                line_in = 1'b1;
                repeat (4) @(negedge clk);
            end
        end

        // R2 / R3: immediate pulse, wait off, or wait on with line high
        pulse_en = 1'b1;
        for (int wm = 0; wm < 2; wm++) begin
            wait_mode = wm[0];
            run_case(0, 0, 0, fl, fd, nl, nd);
            check(fl == 1, wm ? "R3 start index" : "R2 start index", fl, 1);
            check(nl == P, wm ? "R3 pulse length" : "R2 pulse length", nl, P);
            check(fd == P + 1, "R8 done after pulse", fd, P + 1);
            check(nd == 1, "R8 done single", nd, 1);
        end

        // R4 / R5: sweep rising-edge delay across and beyond the wait window
        wait_mode = 1'b1;
        for (int d = 1; d <= W + 2; d++) begin
            set_line_low();
            run_case(d, 0, 0, fl, fd, nl, nd);
            if (d <= W - 2) begin
                exp_low = d + 3; exp_done = d + 3 + P;
                check(fl == exp_low, "R4 deferred start index", fl, exp_low);
                check(nl == P, "R4 deferred pulse length", nl, P);
            end else begin
                exp_done = W + 1;
                check(nl == 0, "R5 dropped no pulse", nl, 0);
            end
            check(fd == exp_done, "R5 R8 done index", fd, exp_done);
            check(nd == 1, "R8 done single in sweep", nd, 1);
            line_in = 1'b1;
            repeat (4) @(negedge clk);
        end

        // R5: never any rise
        set_line_low();
        run_case(0, 0, 0, fl, fd, nl, nd);
        check(nl == 0 && fd == W + 1, "R5 no rise dropped", fd, W + 1);
        line_in = 1'b1;
        repeat (4) @(negedge clk);

        // R6: flip wait_mode during wait, then during a direct pulse
        set_line_low();
        run_case(4, 0, 2, fl, fd, nl, nd);
        check(fl == 7, "R6 wait unaffected by mode change", fl, 7);
        check(nl == P, "R6 pulse length after mode change", nl, P);
        line_in = 1'b1;
        repeat (4) @(negedge clk);
        wait_mode = 1'b0;
        run_case(0, 0, 2, fl, fd, nl, nd);
        check(nl == P && fd == P + 1, "R6 direct pulse unaffected", nl, P);
        wait_mode = 1'b1;

        // R7: strobe during pulse, and during wait
        wait_mode = 1'b0;
        run_case(0, 3, 0, fl, fd, nl, nd);
        check(nl == P && nd == 1 && fd == P + 1, "R7 strobe in pulse ignored", nl, P);
        wait_mode = 1'b1;
        set_line_low();
        run_case(0, 3, 0, fl, fd, nl, nd);
        check(nl == 0 && fd == W + 1, "R7 strobe in wait ignored", fd, W + 1);
        line_in = 1'b1;
        repeat (4) @(negedge clk);

        // R10: no ticks, pulse holds
        wait_mode = 1'b0;
        tick_us = 1'b0;
        @(negedge clk) err_strobe = 1'b1;
        @(negedge clk) err_strobe = 1'b0;
        nl = 0; nd = 0;
        for (int i = 0; i < 20; i++) begin
            if (!drive_low_n) nl++;
            if (done) nd++;
            @(negedge clk);
        end
        check(nl == 20 && nd == 0, "R10 no tick holds pulse", nl, 20);
        tick_us = 1'b1;
        fd = 0;
        for (int i = 1; i <= P + 3; i++) begin
            @(negedge clk);
            if (done && fd == 0) fd = i;
        end
        check(fd == P, "R10 resumes counting", fd, P);

        // R9: edge flag
        edge_clr = 1'b1;
        @(negedge clk) edge_clr = 1'b0;
        check(rx_edge_flag == 1'b0, "R9 cleared", rx_edge_flag, 0);
        line_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rx_edge_flag == 1'b0, "R9 not yet set", rx_edge_flag, 0);
        @(negedge clk);
        check(rx_edge_flag == 1'b1, "R9 set on low", rx_edge_flag, 1);
        edge_clr = 1'b1;
        @(negedge clk);
        check(rx_edge_flag == 1'b0, "R9 clear priority", rx_edge_flag, 0);
        @(negedge clk);
        check(rx_edge_flag == 1'b0, "R9 clear holds", rx_edge_flag, 0);
        edge_clr = 1'b0;
        @(negedge clk);
        check(rx_edge_flag == 1'b1, "R9 resets after clear", rx_edge_flag, 1);
        line_in = 1'b1;
        repeat (3) @(negedge clk);
        edge_clr = 1'b1;
        @(negedge clk) edge_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(rx_edge_flag == 1'b0, "R9 stays clear with high line", rx_edge_flag, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule